// File: doc/BRIEF.md
# Bit-Serial EEPROM Responder Over a Parallel Register Port

This block behaves as a 64-word, 16-bit serial EEPROM. A host reaches it only through register writes and reads on a byte-wide port. Each accepted write to the data register acts as one serial clock edge. The written byte's bit 5 carries the serial input bit. A write to the direction register can abort a command in progress. Reads of the data register return the serial output bit on bit 4.

A command has three parts. It starts with a start bit, then a two-bit opcode, then a six-bit word address sent most significant bit first. After that the block stays in its transfer phase. A read command first returns one dummy zero and then streams word bits, MSB first. A write command stores one bit per accepted data write. In both cases the address moves to the next word after every 16 bits, so long transfers run across consecutive words. The storage comes up from a computed init image on reset.

Top module: `mw_eeprom_responder`

## Requirements
- R1: A write to the data register (`wr_sel`=0) is accepted only when bits 7:6 of `wr_byte` are both 1. Any other data write changes neither the command sequence nor the storage.
- R2: A write to the direction register (`wr_sel`=1) is accepted only when bits 7:6 are both 1. An accepted write copies bits 5:4 to `dir_field`. If bits 5:4 equal 2'b10, it also returns the sequencer to its ready state. With any other value the transfer in progress carries on undisturbed.
- R3: Accepted data writes step through a fixed order: one start bit, then two opcode bits, then six address bits. Bit 5 of the written byte supplies each opcode bit and each address bit, most significant first. After that the transfer phase holds until a restart. Opcode 2'b10 is read and 2'b01 is write.
- R4: During a read command in the transfer phase, the first data-register read returns 0x00. Each later read returns the next stored bit, MSB first, on bit 4 of `rd_byte`, with every other bit 0.
- R5: After the 16th bit of a word, the transfer moves on to the next address, and address 63 is followed by address 0.
- R6: A data-register read returns 0x00 and moves nothing on in two cases: outside the transfer phase, or when the command is anything other than read.
- R7: During a write command in the transfer phase, each accepted data write stores its bit 5 into the current word, MSB first, with no dummy cycle. It uses the same word-advance rule as R5.
- R8: After reset, `rd_byte` and `dir_field` are 0, the sequencer is ready, and the command and address are clear. Word i holds the low 16 bits of (i * 0x1357) XOR `INIT_SEED`, where `INIT_SEED` defaults to 0xA5C3.
- R9: A read result appears on `rd_byte` in the cycle after `rd_en` and holds until the next read. If `rd_en` and `wr_en` are raised in the same cycle, the read is ignored: `rd_byte` keeps its value and the bit stream does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 data register, 1 direction register |
| wr_byte | input | 8 | Written byte |
| rd_en | input | 1 | Data-register read strobe |
| rd_byte | output | 8 | Registered read result |
| dir_field | output | 2 | Last accepted direction field |

## Verification
Read commands are issued to several addresses. These include address 63, where a two-word stream has to wrap to address 0, which separates a correct address increment from a stuck or mis-wrapped one. Rejected bytes are slipped in among the address bits. If any of them were taken as a clock, the returned word would change. A direction write that does not restart is placed in the middle of a stream, to show the bit position is kept. A write command that spans the wrap boundary is read back, to check bit order and word advance on the store side. Reads during a write command or an undefined opcode, and reads raised together with a write, must return zero or hold the previous value.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

   typedef enum logic [2:0] {
      PH_READY,
      PH_OP0,
      PH_OP1,
      PH_ADDR,
      PH_DATA
   } phase_e;

   localparam logic [1:0] CMD_READ  = 2'b10;
   localparam logic [1:0] CMD_WRITE = 2'b01;

   localparam int KEY_HI   = 7;
   localparam int KEY_LO   = 6;
   localparam int DIN_BIT  = 5;
   localparam int DOUT_BIT = 4;
   localparam logic [1:0] DIR_RESTART = 2'b10;

endpackage

// File: rtl/mwe_seq.sv
module mwe_seq
   import mwe_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 16,
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int AIDX_W = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_stb,
   input  logic              din,
   input  logic              restart,
   input  logic              rd_stb,
   output phase_e            phase,
   output logic [ADDR_W-1:0] addr,
   output logic [BIT_W-1:0]  bit_idx,
   output logic              store_we,
   output logic              rd_hit
);

   logic [1:0]        cmd_q;
   logic [AIDX_W-1:0] aidx_q;
   logic              pending_q;
   logic              is_rd, is_wr;

   assign is_rd    = (phase == PH_DATA) && (cmd_q == CMD_READ);
   assign is_wr    = (phase == PH_DATA) && (cmd_q == CMD_WRITE);
   assign store_we = dat_stb && is_wr;
   assign rd_hit   = rd_stb && is_rd && !pending_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_READY;
         cmd_q     <= '0;
         addr      <= '0;
         aidx_q    <= '0;
         bit_idx   <= '0;
         pending_q <= 1'b0;
      end else if (restart) begin
         phase <= PH_READY;
      end else if (dat_stb) begin
         unique case (phase)
            PH_READY: begin
               cmd_q <= '0;
               phase <= PH_OP0;
            end
            PH_OP0: begin
               cmd_q[1]  <= din;
               pending_q <= 1'b1;
               bit_idx   <= '0;
               phase     <= PH_OP1;
            end
            PH_OP1: begin
               cmd_q[0] <= din;
               aidx_q   <= '0;
               phase    <= PH_ADDR;
            end
            PH_ADDR: begin
               addr <= {addr[ADDR_W-2:0], din};
               if (aidx_q == AIDX_W'(ADDR_W - 1)) phase <= PH_DATA;
               else aidx_q <= aidx_q + 1'b1;
            end
            PH_DATA: begin
               if (is_wr) begin
                  pending_q <= 1'b0;
                  if (bit_idx == BIT_W'(WORD_W - 1)) begin
                     bit_idx <= '0;
                     addr    <= addr + 1'b1;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            default: phase <= PH_READY;
         endcase
      end else if (rd_stb && is_rd) begin
         if (pending_q) begin
            pending_q <= 1'b0;
         end else if (bit_idx == BIT_W'(WORD_W - 1)) begin
            bit_idx <= '0;
            addr    <= addr + 1'b1;
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/mwe_store.sv
module mwe_store #(
   parameter int          ADDR_W    = 6,
   parameter int          WORD_W    = 16,
   parameter logic [15:0] INIT_SEED = 16'hA5C3,
   localparam int DEPTH = 2 ** ADDR_W,
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BIT_W-1:0]  bit_idx,
   input  logic              we,
   input  logic              din,
   output logic              rd_bit
);

   function automatic logic [WORD_W-1:0] init_word(input int idx);
      logic [31:0] prod;
      logic [WORD_W-1:0] seed_w;
      prod   = 32'(idx) * 32'h1357;
      seed_w = WORD_W'(INIT_SEED);
      return WORD_W'(prod) ^ seed_w;
   endfunction

   logic [WORD_W-1:0] mem [DEPTH];
   logic [BIT_W-1:0]  pos;
   logic [WORD_W-1:0] cur_word;

   assign pos = BIT_W'(WORD_W - 1) - bit_idx;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= init_word(i);
         else if (we && (addr == ADDR_W'(i))) word_q[pos] <= din;
      end
      assign mem[i] = word_q;
   end

   assign cur_word = mem[addr];
   assign rd_bit   = cur_word[pos];

endmodule

// File: rtl/mw_eeprom_responder.sv
module mw_eeprom_responder
   import mwe_pkg::*;
#(
   parameter int          ADDR_W    = 6,
   parameter int          WORD_W    = 16,
   parameter logic [15:0] INIT_SEED = 16'hA5C3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_byte,
   input  logic       rd_en,
   output logic [7:0] rd_byte,
   output logic [1:0] dir_field
);

   localparam int BIT_W = $clog2(WORD_W);

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("ADDR_W must lie in 2..10");
   end
   if (WORD_W < 2 || WORD_W > 64) begin : g_bad_word
      $error("WORD_W must lie in 2..64");
   end

   logic              keyed, dat_stb, dir_stb, restart, rd_stb;
   logic              store_we, rd_hit, rd_bit;
   logic [ADDR_W-1:0] addr;
   logic [BIT_W-1:0]  bit_idx;
   phase_e            phase;
   logic              unused_low;

   assign unused_low = ^wr_byte[3:0];
   assign keyed   = wr_en && wr_byte[KEY_HI] && wr_byte[KEY_LO];
   assign dat_stb = keyed && !wr_sel;
   assign dir_stb = keyed && wr_sel;
   assign restart = dir_stb && (wr_byte[DIN_BIT:DOUT_BIT] == DIR_RESTART);
   assign rd_stb  = rd_en && !wr_en;

   mwe_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dat_stb  (dat_stb),
      .din      (wr_byte[DIN_BIT]),
      .restart  (restart),
      .rd_stb   (rd_stb),
      .phase    (phase),
      .addr     (addr),
      .bit_idx  (bit_idx),
      .store_we (store_we),
      .rd_hit   (rd_hit)
   );

   mwe_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .INIT_SEED(INIT_SEED)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .bit_idx (bit_idx),
      .we      (store_we),
      .din     (wr_byte[DIN_BIT]),
      .rd_bit  (rd_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_byte   <= '0;
         dir_field <= '0;
      end else begin
         if (dir_stb) dir_field <= wr_byte[DIN_BIT:DOUT_BIT];
         if (rd_stb) begin
            rd_byte <= '0;
            rd_byte[DOUT_BIT] <= rd_hit && rd_bit;
         end
      end
   end

endmodule

// File: rtl/mwe_checker.sv
module mwe_checker
   import mwe_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_sel,
   input logic [7:0] wr_byte,
   input logic       rd_en,
   input logic [7:0] rd_byte,
   input logic [1:0] dir_field,
   input phase_e     phase
);

   p_rd_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte & 8'hEF) == 8'h00);

   p_data_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_byte[7:6] != 2'b11) |=> $stable(phase));

   p_dir_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_byte[7:6] != 2'b11) |=> $stable(dir_field));

   p_dir_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_byte[7:4] == 4'b1110) |=> phase == PH_READY);

   p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_byte[7:6] == 2'b11 && phase == PH_READY) |=> phase == PH_OP0);

   p_rd_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && phase != PH_DATA) |=> rd_byte == 8'h00);

   p_rd_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en) |=> $stable(rd_byte));

endmodule

bind mw_eeprom_responder mwe_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_byte   (wr_byte),
   .rd_en     (rd_en),
   .rd_byte   (rd_byte),
   .dir_field (dir_field),
   .phase     (phase)
);

// File: tb/mw_eeprom_responder_test.sv
module mw_eeprom_responder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_byte;
   logic [1:0] dir_field;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] model [64];

   localparam int N_VEC = 4;
   localparam int T_ADDR [N_VEC] = '{5, 0, 63, 42};
   localparam int T_CNT  [N_VEC] = '{2, 1, 2, 1};

   always #4 clk = ~clk;

   mw_eeprom_responder uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_byte(wr_byte), .rd_en(rd_en), .rd_byte(rd_byte), .dir_field(dir_field)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr_dat(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_byte = b;
      @(negedge clk); wr_en = 1'b0; wr_byte = 8'h00;
   endtask

   task automatic wr_dir(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_byte = b;
      @(negedge clk); wr_en = 1'b0; wr_sel = 1'b0; wr_byte = 8'h00;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; v = rd_byte;
   endtask

   function automatic logic [7:0] bit_byte(input logic b);
      return {3'b000, b, 4'b0000};
   endfunction

   task automatic send_bit(input logic b);
      wr_dat({2'b11, b, 5'b00000});
   endtask

   task automatic start_cmd(input logic [1:0] c, input logic [5:0] a);
      send_bit(1'b1);
      send_bit(c[1]);
      send_bit(c[0]);
      for (int k = 5; k >= 0; k--) send_bit(a[k]);
   endtask

   task automatic rd_bits(input string req, input logic [15:0] w, input int from, input int to);
      logic [7:0] v;
      for (int k = from; k <= to; k++) begin
         rd(v);
         chk(req, v, bit_byte(w[15-k]));
      end
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] held;
      logic [5:0] a;
      for (int i = 0; i < 64; i++) model[i] = 16'(32'(i) * 32'h1357) ^ 16'hA5C3;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 rd_byte after reset", rd_byte, 8'h00);
      chk("R8 dir_field after reset", {6'b0, dir_field}, 8'h00);
      rd(v);
      chk("R6 read in ready state", v, 8'h00);

      // table of read streams
      for (int t = 0; t < N_VEC; t++) begin
         wr_dir(8'hE0);
         chk("R2 restart field", {6'b0, dir_field}, 8'h02);
         a = 6'(T_ADDR[t]);
         start_cmd(2'b10, a);
         rd(v);
         chk("R4 dummy first read", v, 8'h00);
         for (int w = 0; w < T_CNT[t]; w++)
            rd_bits("R5 R4 streamed word", model[6'(a + 6'(w))], 0, 15);
      end

      // rejected bytes among the address bits, mid-stream direction writes
      wr_dir(8'hE0);
      wr_dat(8'h40);
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b0); send_bit(1'b0);
      wr_dat(8'h60);
      send_bit(1'b0);
      wr_dat(8'h20);
      send_bit(1'b0); send_bit(1'b1);
      wr_dat(8'hA0);
      send_bit(1'b1);
      rd(v);
      chk("R1 dummy after rejected writes", v, 8'h00);
      rd_bits("R1 word 3 intact", model[3], 0, 7);
      wr_dir(8'hD0);
      chk("R2 non-restart field", {6'b0, dir_field}, 8'h01);
      rd_bits("R2 stream kept position", model[3], 8, 15);
      wr_dir(8'h60);
      chk("R2 rejected direction write", {6'b0, dir_field}, 8'h01);

      // simultaneous read and write
      wr_dir(8'hE0);
      start_cmd(2'b10, 6'd10);
      rd(v);
      rd(v);
      chk("R9 first bit", v, bit_byte(model[10][15]));
      held = v;
      @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_byte = 8'h00; rd_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      chk("R9 blocked read holds", rd_byte, held);
      @(negedge clk);
      chk("R9 idle holds", rd_byte, held);
      rd_bits("R9 stream not advanced", model[10], 1, 15);

      // undefined opcode gives zeros
      wr_dir(8'hE0);
      start_cmd(2'b11, 6'd5);
      for (int k = 0; k < 3; k++) begin
         rd(v);
         chk("R6 R3 undefined opcode read", v, 8'h00);
      end

      // write across the wrap boundary
      wr_dir(8'hE0);
      start_cmd(2'b01, 6'd63);
      begin
         logic [31:0] pat;
         pat = {16'h1234, 16'hBEEF};
         for (int k = 31; k >= 0; k--) begin
            send_bit(pat[k]);
            if (k == 20) begin
               rd(v);
               chk("R6 read during write command", v, 8'h00);
            end
         end
         model[63] = 16'h1234;
         model[0]  = 16'hBEEF;
      end
      wr_dir(8'hE0);
      start_cmd(2'b10, 6'd63);
      rd(v);
      chk("R4 dummy before readback", v, 8'h00);
      rd_bits("R7 word 63 written", model[63], 0, 15);
      rd_bits("R7 R5 word 0 written after wrap", model[0], 0, 15);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule